// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block produces the serial clock of an I2C master on an open-drain line. It never drives the line high. It has one output that, when asserted, pulls SCL low, and it reads the line back through a sampled input. Each clock period has two parts. In the low part the block holds the line down for a programmed number of reference cycles. In the high part the block lets go of the line. It then waits both for a nominal high count, which starts at the release, and for a minimum high count, which starts only once the line is actually seen high.

Other devices on the bus can shorten or stretch the clock, and the block follows them:

- When another device is still holding the line low after the low count has run out, the block keeps the line released and waits.
- When another device pulls the line low during the high part, the block ends its high part at once and starts a new low part.

The three counts are written into a holding copy at any time. They are copied into the working copy only when an idle block receives a start request, so a transfer in progress always runs with one fixed timing.

An outer controller starts and stops the clock with single-cycle requests. The data path receives a one-cycle strobe at each sensed rising edge of SCL.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset the block is idle, SCL is released, and the strobe is low. The holding copy holds nominal high 500, nominal low 500 and minimum high 401. A start with no prior write therefore gives a low part of 500 cycles and a released part of 500 cycles.
- R2: A start request to an idle block, with no stop request in the same cycle, makes the block busy and asserts the pull-low output in the next cycle.
- R3: Each low part holds the pull-low output for exactly max(L,1) cycles, where L is the nominal low count.
- R4: When no other device drives the line, the released part lasts max(H, M'+3) cycles, where H is the nominal high count (treated as at least 1) and M' = max(M,1) is the minimum high count. The nominal count starts at the release.
- R5: The minimum high count starts when a rising edge is sensed after a two-flop synchroniser. The pull-low output is not asserted until M' cycles after that, so the line is high for at least M'+3 cycles after it rises.
- R6: If the line stays low after the low count has expired, the pull-low output stays deasserted until the line is sensed high.
- R7: If the line falls during the high part while the block has it released, the pull-low output asserts 3 cycles after the fall, without waiting for the counts.
- R8: Writes to the holding copy while the block is busy do not change the running timing. They take effect at the next start from idle.
- R9: A stop request makes the block idle in the next cycle, with SCL released. When start and stop arrive in the same cycle, stop wins.
- R10: The rise strobe is high for exactly one cycle, 2 cycles after the line rises, and only while the block is busy.
- R11: A count of zero behaves as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (10 ns in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the holding copy of the timing counts |
| cfg_high | input | CNT_W | Nominal high count to hold |
| cfg_low | input | CNT_W | Nominal low count to hold |
| cfg_minh | input | CNT_W | Minimum high count to hold |
| start_req | input | 1 | Start the clock (loads the working copy when idle) |
| stop_req | input | 1 | Stop the clock and release the line |
| scl_in | input | 1 | Asynchronous sample of the SCL line |
| scl_drive_low | output | 1 | Pull-low enable for the open-drain SCL driver |
| scl_rise_stb | output | 1 | One-cycle strobe at each sensed SCL rise while busy |
| busy | output | 1 | Clock generation running |

## Verification
Results appear on fixed cycles:

- After a start, the pull-low output is checked at the very next falling clock edge.
- A stop shows up as idle one cycle later.
- A rise of the line gives the strobe on the second cycle after the rise.
- A foreign pull-low during the high part shows up as the block's own pull-low on the third cycle.
- After a stretched low part, the block pulls low M'+3 cycles after the line is freed.

The bench samples every output on the falling clock edge. It counts cycles from the edge at which it changed the line or a request, and compares those counts against the values above. Phase lengths are measured as run lengths of the pull-low output, counted at the same falling-edge sample point.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_LOW     = 2'd1,
    PH_RELEASE = 2'd2,
    PH_HIGH    = 2'd3
  } scl_phase_e;

endpackage

// File: rtl/scl_sync_edge.sv
module scl_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  assign chain_d[0] = din;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      assign chain_d[i] = chain_q[i-1];
    end
  endgenerate

  // Reset to the released (high) level so no false edge follows reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/scl_count_sat.sv
module scl_count_sat #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] last;

  // A limit of zero is treated as one cycle.
  assign last = (limit == '0) ? '0 : limit - 1'b1;
  assign done = (cnt_q >= last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (!done) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/scl_timing_shadow.sv
module scl_timing_shadow #(
  parameter int          W      = 16,
  parameter logic [W-1:0] RST_HI = 16'd500,
  parameter logic [W-1:0] RST_LO = 16'd500,
  parameter logic [W-1:0] RST_MN = 16'd401
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_high,
  input  logic [W-1:0] wr_low,
  input  logic [W-1:0] wr_minh,
  input  logic         load,
  output logic [W-1:0] act_high,
  output logic [W-1:0] act_low,
  output logic [W-1:0] act_minh
);

  localparam int NFIELD = 3;

  logic [W-1:0] rst_val [NFIELD];
  logic [W-1:0] wr_val  [NFIELD];
  logic [W-1:0] hold_q  [NFIELD];
  logic [W-1:0] act_q   [NFIELD];

  assign rst_val[0] = RST_HI;
  assign rst_val[1] = RST_LO;
  assign rst_val[2] = RST_MN;
  assign wr_val[0]  = wr_high;
  assign wr_val[1]  = wr_low;
  assign wr_val[2]  = wr_minh;

  generate
    for (genvar f = 0; f < NFIELD; f++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hold_q[f] <= rst_val[f];
        end else if (wr_en) begin
          hold_q[f] <= wr_val[f];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          act_q[f] <= rst_val[f];
        end else if (load) begin
          act_q[f] <= hold_q[f];
        end
      end
    end
  endgenerate

  assign act_high = act_q[0];
  assign act_low  = act_q[1];
  assign act_minh = act_q[2];

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import i2c_scl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       stop_req,
  input  logic       lo_done,
  input  logic       hi_done,
  input  logic       mn_done,
  input  logic       line_level,
  input  logic       line_rise,
  output scl_phase_e phase,
  output logic       load
);

  scl_phase_e ph_q;
  scl_phase_e ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:    if (start_req) ph_d = PH_LOW;
      PH_LOW:     if (lo_done) ph_d = PH_RELEASE;
      PH_RELEASE: if (line_rise) ph_d = PH_HIGH;
      PH_HIGH: begin
        if (!line_level) begin
          ph_d = PH_LOW;
        end else if (hi_done && mn_done) begin
          ph_d = PH_LOW;
        end
      end
      default:    ph_d = PH_IDLE;
    endcase
    if (stop_req) begin
      ph_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign phase = ph_q;
  assign load  = (ph_q == PH_IDLE) && start_req && !stop_req;

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_scl_pkg::*;
#(
  parameter int             CNT_W       = 16,
  parameter int             SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] RST_HIGH  = 16'd500,
  parameter logic [CNT_W-1:0] RST_LOW   = 16'd500,
  parameter logic [CNT_W-1:0] RST_MINH  = 16'd401
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_minh,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             scl_rise_stb,
  output logic             busy
);

  logic [CNT_W-1:0] act_high;
  logic [CNT_W-1:0] act_low;
  logic [CNT_W-1:0] act_minh;
  logic             load;
  logic             line_level;
  logic             line_rise;
  logic             lo_done;
  logic             hi_done;
  logic             mn_done;
  logic             lo_clr;
  logic             hi_clr;
  logic             mn_clr;
  scl_phase_e       phase;

  scl_timing_shadow #(
    .W      (CNT_W),
    .RST_HI (RST_HIGH),
    .RST_LO (RST_LOW),
    .RST_MN (RST_MINH)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_high  (cfg_high),
    .wr_low   (cfg_low),
    .wr_minh  (cfg_minh),
    .load     (load),
    .act_high (act_high),
    .act_low  (act_low),
    .act_minh (act_minh)
  );

  scl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (scl_in),
    .level (line_level),
    .rise  (line_rise)
  );

  // Low counter runs only in the low phase; nominal high counter runs from
  // release; minimum high counter runs only after the sensed rising edge.
  assign lo_clr = (phase != PH_LOW);
  assign hi_clr = (phase == PH_IDLE) || (phase == PH_LOW);
  assign mn_clr = (phase != PH_HIGH);

  scl_count_sat #(.W(CNT_W)) u_lo_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (lo_clr),
    .limit (act_low),
    .done  (lo_done)
  );

  scl_count_sat #(.W(CNT_W)) u_hi_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hi_clr),
    .limit (act_high),
    .done  (hi_done)
  );

  scl_count_sat #(.W(CNT_W)) u_mn_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mn_clr),
    .limit (act_minh),
    .done  (mn_done)
  );

  scl_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .lo_done    (lo_done),
    .hi_done    (hi_done),
    .mn_done    (mn_done),
    .line_level (line_level),
    .line_rise  (line_rise),
    .phase      (phase),
    .load       (load)
  );

  assign scl_drive_low = (phase == PH_LOW);
  assign busy          = (phase != PH_IDLE);
  assign scl_rise_stb  = line_rise && busy;

endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_req,
  input logic             stop_req,
  input logic             scl_drive_low,
  input logic             scl_rise_stb,
  input logic             busy,
  input logic [CNT_W-1:0] act_high,
  input logic [CNT_W-1:0] act_low,
  input logic [CNT_W-1:0] act_minh
);

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scl_drive_low);

  assert_start_pulls_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !stop_req && !busy) |=> (busy && scl_drive_low));

  assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !busy);

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_stb |=> !scl_rise_stb);

  assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_stb |-> busy);

  assert_shadow_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(act_high) && $stable(act_low) && $stable(act_minh)));

endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_req     (start_req),
  .stop_req      (stop_req),
  .scl_drive_low (scl_drive_low),
  .scl_rise_stb  (scl_rise_stb),
  .busy          (busy),
  .act_high      (act_high),
  .act_low       (act_low),
  .act_minh      (act_minh)
);

// File: tb/tb_i2c_scl_gen.sv
`timescale 1ns/100ps
module tb_i2c_scl_gen;

  localparam int W  = 16;
  localparam int NV = 4;
  // fields: high, low, minh, expected low run, expected released run
  localparam int VEC [NV][5] = '{
    '{10, 8, 4, 8, 10},
    '{5,  6, 9, 6, 12},
    '{0,  0, 0, 1, 4},
    '{3, 20, 3, 20, 6}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_we;
  logic [W-1:0] cfg_high, cfg_low, cfg_minh;
  logic         start_req, stop_req;
  logic         ext_low;
  logic         scl_in;
  logic         dl, stb, busy;
  int           n_chk = 0;
  int           n_bad = 0;

  always #2.5 clk = ~clk;

  assign scl_in = ~(dl | ext_low);

  i2c_scl_gen dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_high      (cfg_high),
    .cfg_low       (cfg_low),
    .cfg_minh      (cfg_minh),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .scl_in        (scl_in),
    .scl_drive_low (dl),
    .scl_rise_stb  (stb),
    .busy          (busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input int h, input int l, input int m);
    cfg_we = 1'b1; cfg_high = W'(h); cfg_low = W'(l); cfg_minh = W'(m);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_start();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(busy && dl, "R2 start pulls low", int'(dl), 1);
  endtask

  task automatic do_stop();
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk(!busy && !dl, "R9 stop idles and releases", int'(busy), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic measure(output int lo, output int hi);
    while (dl) @(negedge clk);
    while (!dl) @(negedge clk);
    lo = 0;
    while (dl) begin lo++; @(negedge clk); end
    hi = 0;
    while (!dl) begin hi++; @(negedge clk); end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int lo, hi, k, nstb;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_high = '0; cfg_low = '0; cfg_minh = '0;
    start_req = 1'b0; stop_req = 1'b0; ext_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and defaults
    chk(!busy && !dl && !stb, "R1 reset idle released", int'(busy), 0);
    do_start();
    measure(lo, hi);
    chk(lo == 500, "R1 default low", lo, 500);
    chk(hi == 500, "R1 default high", hi, 500);
    do_stop();

    // Vector table: R3 low, R4/R5 released length, R11 zero counts, R10 strobe
    for (int v = 0; v < NV; v++) begin
      write_cfg(VEC[v][0], VEC[v][1], VEC[v][2]);
      do_start();
      measure(lo, hi);
      chk(lo == VEC[v][3], "R3 R11 low length", lo, VEC[v][3]);
      chk(hi == VEC[v][4], "R4 R5 R11 released length", hi, VEC[v][4]);
      while (dl) @(negedge clk);
      chk(!stb, "R10 no strobe at release", int'(stb), 0);
      @(negedge clk);
      chk(!stb, "R10 no strobe one after release", int'(stb), 0);
      @(negedge clk);
      chk(stb, "R10 strobe two after rise", int'(stb), 1);
      @(negedge clk);
      chk(!stb, "R10 strobe one cycle", int'(stb), 0);
      do_stop();
    end

    // R10 no strobe while idle
    nstb = 0;
    ext_low = 1'b1;
    repeat (3) @(negedge clk);
    ext_low = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (stb) nstb++;
      @(negedge clk);
    end
    chk(nstb == 0, "R10 idle no strobe", nstb, 0);

    // R6 stretched low
    write_cfg(5, 4, 6);
    start_req = 1'b1;
    ext_low = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(!dl && busy, "R6 released while stretched", int'(dl), 0);
    ext_low = 1'b0;
    k = 0; nstb = 0;
    while (!dl && k < 100) begin
      @(negedge clk);
      k++;
      if (stb) nstb++;
    end
    chk(k == 9, "R6 R5 pull-low after stretch", k, 9);
    chk(nstb == 1, "R10 one strobe per rise", nstb, 1);
    do_stop();

    // R7 early end of high phase
    write_cfg(40, 4, 30);
    do_start();
    while (dl) @(negedge clk);
    repeat (10) @(negedge clk);
    ext_low = 1'b1;
    k = 0;
    while (!dl && k < 100) begin @(negedge clk); k++; end
    ext_low = 1'b0;
    chk(k == 3, "R7 early pull-low delay", k, 3);
    do_stop();

    // R8 shadow: write during run has no effect until restart
    write_cfg(6, 10, 2);
    do_start();
    measure(lo, hi);
    chk(lo == 10, "R8 first timing", lo, 10);
    write_cfg(6, 3, 2);
    measure(lo, hi);
    chk(lo == 10, "R8 write while busy ignored", lo, 10);
    do_stop();
    do_start();
    measure(lo, hi);
    chk(lo == 3, "R8 new timing after restart", lo, 3);
    do_stop();

    // R9 stop wins over start
    start_req = 1'b1; stop_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0; stop_req = 1'b0;
    chk(!busy && !dl, "R9 stop beats start", int'(busy), 0);

    finish_run();
  end

endmodule